// File: doc/BRIEF.md
# Write Data Interleave Order Checker

This block is a passive monitor for the write address and write data channels of a link that follows the older AXI3 rules, where write data from different transactions may be interleaved. It never drives the bus and never stalls it. It only watches for handshakes, which happen when VALID and READY are both high at a rising clock edge. Each accepted write address is recorded in an in-order tracker together with its ID and burst length.

Every accepted write data beat is checked against the outstanding transactions. The beat's ID must belong to an accepted address. The first beats of the transactions must arrive in the order the addresses were accepted. No more transactions may be open at once than the configured slave interleaving depth. Each burst must carry exactly AWLEN+1 beats, with WLAST on the final beat only. After the first start, later beats of different open transactions may be freely mixed.

The first violation sets a sticky error flag and latches a code. Both stay until a synchronous reset. A design instantiates the monitor next to a slave port and watches `err` in simulation or in a debug build.

Top module: `wr_interleave_checker`

## Requirements
- R1: After a synchronous reset, `err` is 0 and `err_code` is 0.
- R2: An accepted data beat whose ID matches no accepted address raises code 1. This covers an ID that is neither open nor waiting to start.
- R3: A data beat that would start a transaction other than the oldest unstarted one raises code 2. The offending beat's ID belongs to an address that is waiting to start, or to one accepted in the same cycle.
- R4: When DEPTH is at least 4, freely mixed continuation beats are accepted without error. An example is address order B, C, A, D with beats B0 C0 C1 A0 A1 D0 B1 C2 A2 A3 D1 D2.
- R5: A transaction is open from its first beat up to its WLAST beat. Starting a new transaction while DEPTH transactions are open raises code 3. With DEPTH = 1 this forces each burst to be sent whole and in address order.
- R6: WLAST must be high exactly on beat number AWLEN+1 of its burst. An early WLAST, or a final beat without WLAST, raises code 4.
- R7: The tracker holds up to TRK addresses, 8 by default. An address handshake while it is full raises code 5.
- R8: An address and the first data beat of that same transaction may both handshake in one cycle. With nothing older waiting, this is legal.
- R9: The error flag and code hold the first violation. Later violations change neither, and only reset clears them.
- R10: VALID without READY on either channel is not a transfer and has no effect on checking.
- R11: When a data-beat violation and a tracker overflow occur in the same cycle, the data-beat code is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awid | input | ID_W | Write address ID |
| awlen | input | LEN_W | Burst length minus one |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wid | input | ID_W | Write data ID |
| wlast | input | 1 | Final beat of burst |
| err | output | 1 | Sticky violation flag |
| err_code | output | 3 | First violation: 1 unknown ID, 2 start order, 3 depth, 4 WLAST, 5 overflow |

## Verification
The assertions rely on reset being applied before the first transfer. They also rely on the ID and length inputs being stable while they are sampled at a handshake. Neither of these is a bus rule the monitor itself checks. The random stimulus meets these assumptions by driving every input only at the falling edge.

The random stimulus keeps IDs distinct within a round so that no two open bursts share an ID. It keeps the number of open bursts within the depth, and it issues all addresses before the data. In this way the legal rounds stay legal by construction. The rounds that inject a fault use only an ID outside the round's set, so their expected code is always 1.

// File: rtl/wr_interleave_checker.sv
module wr_interleave_checker #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4,
  parameter int TRK   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             awvalid,
  input  logic             awready,
  input  logic [ID_W-1:0]  awid,
  input  logic [LEN_W-1:0] awlen,
  input  logic             wvalid,
  input  logic             wready,
  input  logic [ID_W-1:0]  wid,
  input  logic             wlast,
  output logic             err,
  output logic [2:0]       err_code
);
  localparam int IW = (TRK > 1) ? $clog2(TRK) : 1;
  localparam int CW = $clog2(TRK + 1);

  logic [TRK-1:0]   busy, started;
  logic [ID_W-1:0]  s_id  [TRK];
  logic [LEN_W-1:0] s_len [TRK];
  logic [LEN_W-1:0] s_cnt [TRK];
  logic [IW-1:0]    head, tail, nstart;
  logic [CW-1:0]    occ;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(TRK - 1)) ? '0 : p + IW'(1);
  endfunction

  wire aw_hs = awvalid & awready;
  wire w_hs  = wvalid & wready;
  wire full  = (occ == CW'(TRK));

  logic          hit, pend_any, id_waiting;
  logic [IW-1:0] hit_idx;
  logic [CW-1:0] act_cnt;

  always_comb begin
    hit = 1'b0; hit_idx = '0; act_cnt = '0; pend_any = 1'b0; id_waiting = 1'b0;
    for (int i = 0; i < TRK; i++) begin
      if (busy[i] && started[i]) begin
        act_cnt = act_cnt + CW'(1);
        if (s_id[i] == wid) begin hit = 1'b1; hit_idx = IW'(i); end
      end
      if (busy[i] && !started[i]) begin
        pend_any = 1'b1;
        if (s_id[i] == wid) id_waiting = 1'b1;
      end
    end
  end

  wire first_q  = pend_any && (s_id[nstart] == wid);
  wire first_aw = !pend_any && aw_hs && !full && (awid == wid);
  wire [LEN_W-1:0] first_len = first_q ? s_len[nstart] : awlen;
  wire cont_last = (s_cnt[hit_idx] == s_len[hit_idx]);

  logic [2:0] w_code, code_now;
  always_comb begin
    w_code = 3'd0;
    if (w_hs) begin
      if (hit)
        w_code = (wlast != cont_last) ? 3'd4 : 3'd0;
      else if (first_q || first_aw) begin
        if (act_cnt >= CW'(DEPTH))               w_code = 3'd3;
        else if (wlast != (first_len == '0))     w_code = 3'd4;
      end
      else if (id_waiting || (aw_hs && awid == wid)) w_code = 3'd2;
      else                                           w_code = 3'd1;
    end
    code_now = (w_code != 3'd0) ? w_code : ((aw_hs && full) ? 3'd5 : 3'd0);
  end

  wire upd    = !err && (code_now == 3'd0);
  wire retire = (occ != '0) && !busy[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0; err_code <= 3'd0;
      busy <= '0; started <= '0;
      head <= '0; tail <= '0; nstart <= '0; occ <= '0;
      for (int i = 0; i < TRK; i++) begin
        s_id[i] <= '0; s_len[i] <= '0; s_cnt[i] <= '0;
      end
    end else begin
      if (!err && code_now != 3'd0) begin
        err <= 1'b1; err_code <= code_now;
      end
      if (upd) begin
        if (aw_hs) begin
          s_id[tail]  <= awid;
          s_len[tail] <= awlen;
          if (w_hs && first_aw) begin
            busy[tail] <= !wlast; started[tail] <= 1'b1; s_cnt[tail] <= LEN_W'(1);
          end else begin
            busy[tail] <= 1'b1; started[tail] <= 1'b0; s_cnt[tail] <= '0;
          end
          tail <= nxt(tail);
        end
        if (w_hs && hit) begin
          if (wlast) busy[hit_idx] <= 1'b0;
          else       s_cnt[hit_idx] <= s_cnt[hit_idx] + LEN_W'(1);
        end
        if (w_hs && first_q) begin
          started[nstart] <= 1'b1;
          s_cnt[nstart]   <= LEN_W'(1);
          if (wlast) busy[nstart] <= 1'b0;
        end
        if (w_hs && (first_q || first_aw)) nstart <= nxt(nstart);
        if (retire) head <= nxt(head);
        occ <= occ + CW'(aw_hs) - CW'(retire);
      end
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err && $stable(err_code));
  p_code_range_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code >= 3'd1 && err_code <= 3'd5));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(TRK));
  p_overflow_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (aw_hs && full && !w_hs && !err) |=> (err && err_code == 3'd5));
  p_depth_r5: assert property (@(posedge clk) disable iff (rst)
    !err |-> (act_cnt <= CW'(DEPTH)));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!aw_hs && !w_hs && !err) |=> !err);
endmodule

// File: tb/wr_interleave_checker_tb.sv
module wr_interleave_checker_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       awvalid = 0, awready = 0, wvalid = 0, wready = 0, wlast = 0;
  logic [3:0] awid = 0, awlen = 0, wid = 0;
  logic       err;
  logic [2:0] err_code;
  int checks = 0, errors = 0;
  bit done = 0;

  wr_interleave_checker u_dut (
    .clk(clk), .rst(rst), .awvalid(awvalid), .awready(awready), .awid(awid),
    .awlen(awlen), .wvalid(wvalid), .wready(wready), .wid(wid), .wlast(wlast),
    .err(err), .err_code(err_code));

  task automatic drive(input logic av, input logic ar, input logic [3:0] ai,
                       input logic [3:0] al, input logic wv, input logic wr,
                       input logic [3:0] wi, input logic wl);
    @(negedge clk);
    awvalid = av; awready = ar; awid = ai; awlen = al;
    wvalid = wv; wready = wr; wid = wi; wlast = wl;
  endtask
  task automatic idle(); drive(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic aw(input logic [3:0] i, input logic [3:0] l); drive(1, 1, i, l, 0, 0, 0, 0); endtask
  task automatic wb(input logic [3:0] i, input logic l); drive(0, 0, 0, 0, 1, 1, i, l); endtask
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask
  task automatic check(input logic ee, input logic [2:0] ec, input string tag);
    checks++;
    if (err !== ee || err_code !== ec) begin
      errors++;
      $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d", tag, err, err_code, ee, ec);
    end
  endtask
  function automatic logic [2:0] exp_code(input bit corrupt);
    return corrupt ? 3'd1 : 3'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] ids [6];
    int lens [6], cnt [6];
    bit act [6], ok, corrupt;
    int n, base, nx, acts, left, beatno, bad_at, k, pick;
    logic [3:0] bad;
    void'($urandom(32'd1234));

    do_reset();
    check(0, 0, "R1 reset state");

    // R4: address order B C A D and a mixed beat stream
    aw(2, 1); aw(3, 2); aw(1, 3); aw(4, 2);
    wb(2, 0); wb(3, 0); wb(3, 0); wb(1, 0); wb(1, 0); wb(4, 0);
    wb(2, 1); wb(3, 1); wb(1, 0); wb(1, 1); wb(4, 0); wb(4, 1);
    idle(); check(0, 0, "R4 example interleave accepted");

    do_reset(); aw(1, 0); wb(5, 1); idle();
    check(1, 1, "R2 unknown id");

    do_reset(); aw(1, 0); aw(2, 0); wb(2, 1); idle();
    check(1, 2, "R3 start order");

    do_reset();
    for (int i = 1; i <= 5; i++) aw(4'(i), 1);
    for (int i = 1; i <= 4; i++) wb(4'(i), 0);
    idle(); check(0, 0, "R5 four open within depth");
    wb(5, 0); idle(); check(1, 3, "R5 fifth start over depth");

    do_reset(); aw(1, 2); wb(1, 1); idle();
    check(1, 4, "R6 early wlast");
    do_reset(); aw(1, 1); wb(1, 0); wb(1, 0); idle();
    check(1, 4, "R6 missing wlast");

    do_reset();
    for (int i = 0; i < 8; i++) aw(4'(i), 0);
    idle(); check(0, 0, "R7 tracker at capacity");
    aw(8, 0); idle(); check(1, 5, "R7 overflow");

    do_reset();
    for (int i = 0; i < 8; i++) aw(4'(i), 0);
    drive(1, 1, 8, 0, 1, 1, 9, 1); idle();
    check(1, 1, "R11 data error wins over overflow");

    do_reset();
    drive(1, 1, 3, 0, 1, 1, 3, 1); idle();
    check(0, 0, "R8 same-cycle single beat");
    drive(1, 1, 6, 1, 1, 1, 6, 0); wb(6, 1); aw(7, 0); wb(7, 1); idle();
    check(0, 0, "R8 same-cycle first of two");

    do_reset(); aw(1, 0); aw(2, 0); wb(2, 1); wb(9, 1); idle();
    check(1, 2, "R9 first code kept");
    do_reset(); check(0, 0, "R9 reset clears");

    do_reset();
    drive(0, 0, 0, 0, 1, 0, 9, 1); idle();
    check(0, 0, "R10 wvalid without wready ignored");
    drive(1, 0, 5, 0, 0, 0, 0, 0); wb(5, 1); idle();
    check(1, 1, "R10 address without awready not recorded");

    for (int r = 0; r < 40; r++) begin
      do_reset();
      n = 1 + int'($urandom % 6);
      base = int'($urandom % 16);
      corrupt = (r % 5 == 4);
      left = 0;
      for (int j = 0; j < n; j++) begin
        ids[j] = 4'((base + 3 * j) % 16);
        lens[j] = int'($urandom % 4);
        cnt[j] = 0; act[j] = 0;
        left += lens[j] + 1;
      end
      bad = 0;
      for (int c = 15; c >= 0; c--) begin
        ok = 1;
        for (int j = 0; j < n; j++) if (ids[j] == 4'(c)) ok = 0;
        if (ok) bad = 4'(c);
      end
      bad_at = int'($urandom % left);
      for (int j = 0; j < n; j++) begin
        if ($urandom % 3 == 0) drive(1, 0, bad, 0, 0, 0, 0, 0);
        aw(ids[j], 4'(lens[j]));
      end
      nx = 0; acts = 0; beatno = 0;
      while (left > 0) begin
        if ($urandom % 4 == 0) drive(0, 0, 0, 0, 1, 0, bad, 1);
        if (corrupt && beatno == bad_at) begin
          wb(bad, 1);
          break;
        end
        if (nx < n && acts < 4 && (acts == 0 || $urandom % 2 == 0)) begin
          k = nx; nx++; act[k] = 1; acts++;
        end else begin
          pick = int'($urandom % 6);
          k = -1;
          for (int s = 0; s < 6; s++)
            if (k < 0 && act[(pick + s) % 6]) k = (pick + s) % 6;
        end
        wb(ids[k], cnt[k] == lens[k]);
        if (cnt[k] == lens[k]) begin act[k] = 0; acts--; end
        cnt[k]++; left--; beatno++;
      end
      idle();
      check(corrupt, exp_code(corrupt), corrupt ? "R2 random injected id" : "R4 random legal mix");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule